// File: doc/BRIEF.md
# Exception entry and vectoring controller

This block performs the hardware side of exception entry for a 32-bit processor core. Each clock it looks at the pending exception requests: instruction bus error, data bus error, divide by zero, system call, breakpoint, watchpoint and the hardware interrupt line. It selects the one with the lowest exception number and, one clock later, presents everything the core needs to enter the handler. That is the handler address, a write of the faulting PC into the proper save register, and the updated interrupt-enable bits.

Exceptions fall into two classes. Debug exceptions (breakpoint, watchpoint) save the PC in the breakpoint-address register, keep the old enable state in the debug shadow bit, and always vector from the debug base. All other exceptions save the PC in the exception-address register and keep the old enable state in the normal shadow bit. They vector from the normal base, or from the debug base when the remap control is set. A request that loses arbitration is dropped and must be raised again by its source.

Top module: `exc_entry`

## Requirements
- R1: A taken non-debug exception (cause 2, 4, 5, 6 or 7) drives `ea_we` high for one cycle, with `ea_data` equal to the `pc_cur` sampled at the request edge, and leaves `ba_we` low.
- R2: A taken debug exception (cause 1 breakpoint, cause 3 watchpoint) drives `ba_we` high, with `ba_data` equal to the sampled `pc_cur`, and leaves `ea_we` low.
- R3: On any taken exception `ie_out` is 0. For a non-debug cause `eie_out` becomes `eie_in | ie_in` and `bie_out` equals `bie_in`. For a debug cause `bie_out` becomes `bie_in | ie_in` and `eie_out` equals `eie_in`. A shadow bit is never cleared by entry.
- R4: `pc_vec` equals the selected base with bits 7:0 forced to zero, plus the cause number times 32.
- R5: Debug causes always use `dbase`. Non-debug causes use `dbase` when `remap` is 1 and `ebase` when it is 0.
- R6: The interrupt line takes cause 6 only while `ie_in` is 1. With `ie_in` at 0 it has no effect on any output.
- R7: When several requests are present, the lowest cause number wins. The order is breakpoint 1, instruction bus error 2, watchpoint 3, data bus error 4, divide by zero 5, interrupt 6, system call 7. `cause` reports the winner.
- R8: Outputs change one clock after the request edge. In a cycle with no taken exception, `taken`, `ea_we` and `ba_we` are 0, the three enable outputs copy their inputs, and `pc_vec`, `ea_data`, `ba_data` and `cause` hold their previous values.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_cur | input | 32 | PC of the excepting instruction |
| ie_in | input | 1 | Current interrupt-enable bit |
| eie_in | input | 1 | Current normal shadow enable bit |
| bie_in | input | 1 | Current debug shadow enable bit |
| ebase | input | 32 | Normal exception base |
| dbase | input | 32 | Debug exception base |
| remap | input | 1 | Send non-debug exceptions to the debug base |
| irq | input | 1 | Hardware interrupt line |
| req_ibus | input | 1 | Instruction bus error request |
| req_dbus | input | 1 | Data bus error request |
| req_div | input | 1 | Divide-by-zero request |
| req_sys | input | 1 | System call request |
| req_brk | input | 1 | Breakpoint request |
| req_wch | input | 1 | Watchpoint request |
| taken | output | 1 | An exception was entered this cycle |
| cause | output | 3 | Number of the entered exception |
| pc_vec | output | 32 | Handler address |
| ea_we | output | 1 | Exception-address register write enable |
| ea_data | output | 32 | Exception-address register write data |
| ba_we | output | 1 | Breakpoint-address register write enable |
| ba_data | output | 32 | Breakpoint-address register write data |
| ie_out | output | 1 | Updated interrupt-enable bit |
| eie_out | output | 1 | Updated normal shadow bit |
| bie_out | output | 1 | Updated debug shadow bit |

## Verification
The assertions assume the enable inputs come from the core's own register file and are stable across an edge. They also assume a dropped request is simply raised again by its source, so any mix of request bits in any cycle is legal. The stimulus changes all inputs only on the falling edge. It draws request bits at a low density, so isolated causes, overlapping causes and idle cycles all occur. It mixes directed cases for the full-collision, masked-interrupt and already-set-shadow corners with long random runs.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int XLEN      = 32,
  parameter int ALIGN     = 8,
  parameter int VEC_SHIFT = 5,
  parameter int CW        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_cur,
  input  logic            ie_in,
  input  logic            eie_in,
  input  logic            bie_in,
  input  logic [XLEN-1:0] ebase,
  input  logic [XLEN-1:0] dbase,
  input  logic            remap,
  input  logic            irq,
  input  logic            req_ibus,
  input  logic            req_dbus,
  input  logic            req_div,
  input  logic            req_sys,
  input  logic            req_brk,
  input  logic            req_wch,
  output logic            taken,
  output logic [CW-1:0]   cause,
  output logic [XLEN-1:0] pc_vec,
  output logic            ea_we,
  output logic [XLEN-1:0] ea_data,
  output logic            ba_we,
  output logic [XLEN-1:0] ba_data,
  output logic            ie_out,
  output logic            eie_out,
  output logic            bie_out
);

  localparam logic [XLEN-1:0] BASE_MASK = ~((XLEN'(1) << ALIGN) - XLEN'(1));

  logic          irq_ok;
  logic          any;
  logic [CW-1:0] num;
  logic          dbg;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] vec;

  assign irq_ok = irq & ie_in;
  assign any = req_brk | req_ibus | req_wch | req_dbus | req_div | irq_ok | req_sys;

  always_comb begin
    num = '0;
    if      (req_brk)  num = CW'(1);
    else if (req_ibus) num = CW'(2);
    else if (req_wch)  num = CW'(3);
    else if (req_dbus) num = CW'(4);
    else if (req_div)  num = CW'(5);
    else if (irq_ok)   num = CW'(6);
    else if (req_sys)  num = CW'(7);
  end

  assign dbg  = (num == CW'(1)) || (num == CW'(3));
  assign base = ((dbg || remap) ? dbase : ebase) & BASE_MASK;
  assign vec  = base + (XLEN'(num) << VEC_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken   <= 1'b0;
      cause   <= '0;
      pc_vec  <= '0;
      ea_we   <= 1'b0;
      ea_data <= '0;
      ba_we   <= 1'b0;
      ba_data <= '0;
      ie_out  <= 1'b0;
      eie_out <= 1'b0;
      bie_out <= 1'b0;
    end else begin
      taken   <= any;
      ea_we   <= any & ~dbg;
      ba_we   <= any & dbg;
      ie_out  <= any ? 1'b0 : ie_in;
      eie_out <= eie_in | (any & ~dbg & ie_in);
      bie_out <= bie_in | (any & dbg & ie_in);
      if (any) begin
        cause  <= num;
        pc_vec <= vec;
        if (dbg) ba_data <= pc_cur;
        else     ea_data <= pc_cur;
      end
    end
  end

  a_r2_debug_saves_ba: assert property (@(posedge clk) disable iff (!rst_n)
    req_brk |=> (taken && ba_we && !ea_we && ba_data == $past(pc_cur) && cause == 3'd1));

  a_r1_nondebug_saves_ea: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ibus && !req_brk) |=> (ea_we && !ba_we && ea_data == $past(pc_cur)));

  a_r3_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> !ie_out);

  a_r3_shadow_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (eie_in && bie_in) |=> (eie_out && bie_out));

  a_r6_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ie_in && !req_brk && !req_ibus && !req_wch && !req_dbus && !req_div && !req_sys)
      |=> !taken);

  a_r4_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (pc_vec[VEC_SHIFT-1:0] == '0));

  a_r8_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ea_we, ba_we}) <= 1);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (!ea_we && !ba_we));

endmodule

// File: tb/exc_entry_bench.sv
module exc_entry_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pc_cur, ebase, dbase;
  logic        ie_in, eie_in, bie_in, remap, irq;
  logic        req_ibus, req_dbus, req_div, req_sys, req_brk, req_wch;
  logic        taken, ea_we, ba_we, ie_out, eie_out, bie_out;
  logic [2:0]  cause;
  logic [31:0] pc_vec, ea_data, ba_data;

  int total = 0;
  int bad = 0;

  exc_entry u_exc_entry (
    .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .ie_in(ie_in), .eie_in(eie_in),
    .bie_in(bie_in), .ebase(ebase), .dbase(dbase), .remap(remap), .irq(irq),
    .req_ibus(req_ibus), .req_dbus(req_dbus), .req_div(req_div), .req_sys(req_sys),
    .req_brk(req_brk), .req_wch(req_wch), .taken(taken), .cause(cause),
    .pc_vec(pc_vec), .ea_we(ea_we), .ea_data(ea_data), .ba_we(ba_we),
    .ba_data(ba_data), .ie_out(ie_out), .eie_out(eie_out), .bie_out(bie_out));

  always #10 clk = ~clk;

  logic        m_taken = 0, m_eawe = 0, m_bawe = 0, m_ie = 0, m_eie = 0, m_bie = 0;
  logic [2:0]  m_cause = 0;
  logic [31:0] m_vec = 0, m_ea = 0, m_ba = 0;

  always @(posedge clk) begin
    int n;
    bit d;
    logic [31:0] b;
    if (!rst_n) begin
      m_taken = 0; m_eawe = 0; m_bawe = 0; m_ie = 0; m_eie = 0; m_bie = 0;
      m_cause = 0; m_vec = 0; m_ea = 0; m_ba = 0;
    end else begin
      n = 0;
      if (req_brk) n = 1;
      else if (req_ibus) n = 2;
      else if (req_wch) n = 3;
      else if (req_dbus) n = 4;
      else if (req_div) n = 5;
      else if (irq && ie_in) n = 6;
      else if (req_sys) n = 7;
      d = (n == 1 || n == 3);
      m_taken = (n != 0);
      m_eawe = m_taken && !d;
      m_bawe = m_taken && d;
      m_ie = m_taken ? 1'b0 : ie_in;
      m_eie = eie_in;
      m_bie = bie_in;
      if (m_taken) begin
        if (d) m_bie = bie_in | ie_in; else m_eie = eie_in | ie_in;
        b = (d || remap) ? dbase : ebase;
        b[7:0] = 8'h00;
        m_vec = b + 32'(n * 32);
        m_cause = 3'(n);
        if (d) m_ba = pc_cur; else m_ea = pc_cur;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R8 taken", 32'(taken), 32'(m_taken));
    chk("R7 cause", 32'(cause), 32'(m_cause));
    chk("R4 R5 pc_vec", pc_vec, m_vec);
    chk("R1 ea_we", 32'(ea_we), 32'(m_eawe));
    chk("R1 ea_data", ea_data, m_ea);
    chk("R2 ba_we", 32'(ba_we), 32'(m_bawe));
    chk("R2 ba_data", ba_data, m_ba);
    chk("R3 R6 ie_out", 32'(ie_out), 32'(m_ie));
    chk("R3 eie_out", 32'(eie_out), 32'(m_eie));
    chk("R3 bie_out", 32'(bie_out), 32'(m_bie));
  endtask

  task automatic quiet();
    {req_ibus, req_dbus, req_div, req_sys, req_brk, req_wch, irq} = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=150000", wd);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; quiet(); remap = 0;
    pc_cur = 32'h1000; ebase = 32'h0000_0000; dbase = 32'h0000_0000;
    ie_in = 1; eie_in = 1; bie_in = 1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 taken", 32'(taken), 0);
    chk("R9 pc_vec", pc_vec, 0);
    chk("R9 ie_out", 32'(ie_out), 0);
    chk("R9 eie_out", 32'(eie_out), 0);
    rst_n = 1;
    ie_in = 1; eie_in = 0; bie_in = 0;
    ebase = 32'h4000_12ff; dbase = 32'h8000_03a5; pc_cur = 32'h0000_2468;
    // R7: all requests together, breakpoint wins
    {req_ibus, req_dbus, req_div, req_sys, req_brk, req_wch, irq} = '1;
    step();
    chk("R7 all-collide cause", 32'(cause), 1);
    chk("R5 debug base", pc_vec, 32'h8000_0320);
    // R6: masked interrupt alone
    quiet(); irq = 1; ie_in = 0;
    step();
    chk("R6 masked irq", 32'(taken), 0);
    // R3: shadow already set, IE clear, non-debug
    quiet(); req_div = 1; ie_in = 0; eie_in = 1; remap = 0;
    step();
    chk("R3 shadow kept", 32'(eie_out), 1);
    chk("R4 vector", pc_vec, 32'h4000_12a0);
    // R5: remap sends system call to debug base
    quiet(); req_sys = 1; remap = 1; ie_in = 1; eie_in = 0;
    step();
    chk("R5 remap", pc_vec, 32'h8000_03e0);
    quiet();
    step();
    for (int i = 0; i < 4000; i++) begin
      pc_cur = $urandom; ebase = $urandom; dbase = $urandom;
      ie_in = $urandom; eie_in = $urandom; bie_in = $urandom; remap = $urandom;
      req_brk = ($urandom % 8) == 0; req_ibus = ($urandom % 8) == 0;
      req_wch = ($urandom % 8) == 0; req_dbus = ($urandom % 8) == 0;
      req_div = ($urandom % 8) == 0; irq = ($urandom % 4) == 0;
      req_sys = ($urandom % 8) == 0;
      if (i % 500 == 250) rst_n = 0; else rst_n = 1;
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule